// File: doc/BRIEF.md
# Keyed configuration write gate

This block sits on a simple host write port in front of a bank of protected configuration registers. Writes to those registers pass only after software has placed a fixed 32-bit key in each of two key registers. A further lock flag, kept inside the block, guards the subrange that holds the clock-generator (PLL controller) registers. Software has to clear that flag before it may write them, and set it again afterwards.

Each write produces a one-cycle result pulse in the next cycle. The block asserts `wr_ok_o` if the write was taken and `wr_err_o` if it was dropped. The key state and the PLL lock flag are visible on ports. A small combinational read port returns the lock-flag word and reads the key registers as zero. The protected registers themselves are outside the block. A consumer qualifies its own write with `wr_ok_o`, or repeats the decision from the exported state.

Top module: `cfg_key_gate`

## Requirements
- R1: After reset, `unlocked_o` is 0, `pll_lock_o` is 1, and a read of address 2 returns 0x00000010.
- R2: When address 0 holds 0x83E70B13 and address 1 holds 0x95A4F1E0, `unlocked_o` is 1 from the cycle after the second correct key is written. The two keys may be written in either order.
- R3: With only one correct key written, `unlocked_o` stays 0 and writes to protected addresses are rejected.
- R4: Writing any value other than its own key to address 0 or address 1 clears both key matches, so `unlocked_o` returns to 0.
- R5: Reads of address 0 and address 1 return zero, whatever has been written there.
- R6: A write to any address other than 0 or 1 while `unlocked_o` is 0 is dropped. It produces a one-cycle `wr_err_o` pulse in the following cycle and no `wr_ok_o` pulse. A dropped write to address 2 leaves `pll_lock_o` unchanged.
- R7: While unlocked, a write to address 2 takes data bit 4 as the new PLL lock flag. The flag appears on `pll_lock_o` and at bit 4 of a read of address 2 in the next cycle.
- R8: A write to the PLL range (address 8 and above) is accepted only when `unlocked_o` is 1 and `pll_lock_o` is 0. Otherwise it is rejected with `wr_err_o`.
- R9: While unlocked, writes to addresses 3 to 7 are accepted whatever the state of the PLL lock flag.
- R10: Key writes are always accepted (`wr_ok_o` pulse). A write decision uses the key state present at the start of its cycle. A protected write in the cycle right after the completing key write is therefore accepted, and one right after a wrong key is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write strobe, one write per cycle |
| wr_addr_i | input | 4 | Word address of the write |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 4 | Word address of the read |
| rd_data_o | output | 32 | Read data, combinational |
| wr_ok_o | output | 1 | Pulse: previous-cycle write accepted |
| wr_err_o | output | 1 | Pulse: previous-cycle write dropped |
| unlocked_o | output | 1 | Both key registers hold their keys |
| pll_lock_o | output | 1 | PLL register lock flag |

## Verification
The hardest case to reach is a write to the PLL range that is rejected only because of the lock flag, with the keys valid. It needs the full sequence: both keys written, the flag cleared by a write to address 2, a PLL write accepted, then the flag set again with the keys still in place. The bench also places protected writes in the cycle directly after a completing key and after a wrong key. These show that the decision follows the registered key state.

// File: rtl/cfg_key_gate_pkg.sv
package cfg_key_gate_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 4;
  localparam logic [DATA_W-1:0] KEY_A = 32'h83E7_0B13;
  localparam logic [DATA_W-1:0] KEY_B = 32'h95A4_F1E0;
  localparam logic [ADDR_W-1:0] ADDR_KEY_A = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_KEY_B = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_CFG0  = 4'd2;
  localparam logic [ADDR_W-1:0] PLL_BASE   = 4'd8;
  localparam int unsigned LOCK_BIT = 4;

  typedef enum logic [2:0] {
    RGN_KEY_A, RGN_KEY_B, RGN_CFG0, RGN_GEN, RGN_PLL
  } region_e;

  function automatic region_e decode(input logic [ADDR_W-1:0] a);
    if (a == ADDR_KEY_A)   return RGN_KEY_A;
    if (a == ADDR_KEY_B)   return RGN_KEY_B;
    if (a == ADDR_CFG0)    return RGN_CFG0;
    if (a >= PLL_BASE)     return RGN_PLL;
    return RGN_GEN;
  endfunction
endpackage

// File: rtl/key_match.sv
module key_match
  import cfg_key_gate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  region_e           rgn_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              unlocked_o
);
  logic match_a_q, match_b_q;
  logic hit_a, hit_b, bad;

  assign hit_a = wr_valid_i && rgn_i == RGN_KEY_A;
  assign hit_b = wr_valid_i && rgn_i == RGN_KEY_B;
  assign bad   = (hit_a && data_i != KEY_A) || (hit_b && data_i != KEY_B);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_a_q <= 1'b0;
      match_b_q <= 1'b0;
    end else if (bad) begin
      match_a_q <= 1'b0;  // any wrong key relocks everything
      match_b_q <= 1'b0;
    end else begin
      if (hit_a) match_a_q <= 1'b1;
      if (hit_b) match_b_q <= 1'b1;
    end
  end

  assign unlocked_o = match_a_q && match_b_q;

  assert_wrong_key_relocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |=> !unlocked_o);
endmodule

// File: rtl/pll_lock_reg.sv
module pll_lock_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic bit_i,
  output logic lock_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lock_o <= 1'b1;
    else if (we_i) lock_o <= bit_i;
  end

  assert_lock_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(lock_o));
endmodule

// File: rtl/write_judge.sv
module write_judge
  import cfg_key_gate_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    wr_valid_i,
  input  region_e rgn_i,
  input  logic    unlocked_i,
  input  logic    pll_lock_i,
  output logic    cfg_we_o,
  output logic    wr_ok_o,
  output logic    wr_err_o
);
  logic take;

  always_comb begin
    unique case (rgn_i)
      RGN_KEY_A, RGN_KEY_B: take = 1'b1;
      RGN_PLL:              take = unlocked_i && !pll_lock_i;
      default:              take = unlocked_i;
    endcase
  end

  assign cfg_we_o = wr_valid_i && take && rgn_i == RGN_CFG0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ok_o  <= 1'b0;
      wr_err_o <= 1'b0;
    end else begin
      wr_ok_o  <= wr_valid_i && take;
      wr_err_o <= wr_valid_i && !take;
    end
  end

  assert_err_follows_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |-> $past(wr_valid_i));
endmodule

// File: rtl/cfg_key_gate.sv
module cfg_key_gate
  import cfg_key_gate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              wr_ok_o,
  output logic              wr_err_o,
  output logic              unlocked_o,
  output logic              pll_lock_o
);
  region_e rgn;
  logic    cfg_we;

  assign rgn = decode(wr_addr_i);

  key_match u_keys (
    .clk_i, .rst_ni, .wr_valid_i, .rgn_i(rgn), .data_i(wr_data_i),
    .unlocked_o
  );

  pll_lock_reg u_lock (
    .clk_i, .rst_ni, .we_i(cfg_we), .bit_i(wr_data_i[LOCK_BIT]),
    .lock_o(pll_lock_o)
  );

  write_judge u_judge (
    .clk_i, .rst_ni, .wr_valid_i, .rgn_i(rgn), .unlocked_i(unlocked_o),
    .pll_lock_i(pll_lock_o), .cfg_we_o(cfg_we), .wr_ok_o, .wr_err_o
  );

  always_comb begin
    rd_data_o = '0;  // key registers and unmapped words read zero
    if (rd_addr_i == ADDR_CFG0) rd_data_o[LOCK_BIT] = pll_lock_o;
  end

  assert_locked_reject_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && rgn != RGN_KEY_A && rgn != RGN_KEY_B && !unlocked_o |=> wr_err_o && !wr_ok_o);
  assert_pll_blocked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && rgn == RGN_PLL && pll_lock_o |=> !wr_ok_o);
  assert_key_write_ok_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && (rgn == RGN_KEY_A || rgn == RGN_KEY_B) |=> wr_ok_o);
  assert_lock_needs_unlock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked_o |=> $stable(pll_lock_o));
endmodule

// File: tb/cfg_key_gate_bench.sv
module cfg_key_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KA = 32'h83E7_0B13;
  localparam logic [31:0] KB = 32'h95A4_F1E0;

  logic        clk = 0, rst_n = 0;
  logic        wr_valid = 0;
  logic [3:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic        wr_ok, wr_err, unlocked, pll_lock;
  int checks = 0, errors = 0;
  logic got_ok, got_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_key_gate u_cfg_key_gate (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .wr_ok_o(wr_ok), .wr_err_o(wr_err), .unlocked_o(unlocked), .pll_lock_o(pll_lock)
  );

  task automatic chk(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  // one write cycle; results sampled at the following negedge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
    got_ok = wr_ok; got_err = wr_err;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic do_reset;
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    do_reset();
    chk_eq("R1 unlocked", unlocked, 0);
    chk_eq("R1 pll_lock", pll_lock, 1);
    rd(4'd2, d); chk_eq("R1 cfg0 read", d, 32'h10);
  endtask

  task automatic t_unlock_orders;
    do_reset();
    wr(4'd0, KA); chk_eq("R3 one key", unlocked, 0);
    wr(4'd1, KB); chk_eq("R2 order A,B", unlocked, 1);
    do_reset();
    wr(4'd1, KB); wr(4'd0, KA); chk_eq("R2 order B,A", unlocked, 1);
  endtask

  task automatic t_partial;
    do_reset();
    wr(4'd1, KB);
    wr(4'd5, 32'h1);
    chk_eq("R3 reject err", got_err, 1);
    chk_eq("R3 reject ok", got_ok, 0);
  endtask

  task automatic t_wrong_key;
    do_reset();
    wr(4'd0, KA); wr(4'd1, KB);
    wr(4'd1, KB ^ 32'h1); chk_eq("R4 bad B relocks", unlocked, 0);
    wr(4'd1, KB); chk_eq("R4 A cleared too", unlocked, 0);
    wr(4'd0, KA); chk_eq("R4 relock recover", unlocked, 1);
    wr(4'd0, 32'h0); chk_eq("R4 bad A relocks", unlocked, 0);
  endtask

  task automatic t_read_keys;
    logic [31:0] d;
    do_reset();
    wr(4'd0, KA); wr(4'd1, KB);
    rd(4'd0, d); chk_eq("R5 read key A", d, 0);
    rd(4'd1, d); chk_eq("R5 read key B", d, 0);
  endtask

  task automatic t_locked_drop;
    do_reset();
    wr(4'd2, 32'h0);
    chk_eq("R6 err pulse", got_err, 1);
    chk_eq("R6 no ok", got_ok, 0);
    chk_eq("R6 lock kept", pll_lock, 1);
    @(negedge clk); chk_eq("R6 pulse one cycle", wr_err, 0);
  endtask

  task automatic t_master_lock;
    logic [31:0] d;
    do_reset();
    wr(4'd0, KA); wr(4'd1, KB);
    wr(4'd2, 32'h0);
    chk_eq("R7 cfg write ok", got_ok, 1);
    chk_eq("R7 lock cleared", pll_lock, 0);
    rd(4'd2, d); chk_eq("R7 readback 0", d, 0);
    wr(4'd2, 32'hFFFF_FFEF); chk_eq("R7 only bit 4", pll_lock, 0);
    wr(4'd2, 32'h10); chk_eq("R7 lock set", pll_lock, 1);
  endtask

  task automatic t_pll_gate;
    do_reset();
    wr(4'd9, 32'h1); chk_eq("R8 locked keys", got_err, 1);
    wr(4'd0, KA); wr(4'd1, KB);
    wr(4'd8, 32'h1); chk_eq("R8 flag set reject", got_err, 1);
    chk_eq("R8 flag set no ok", got_ok, 0);
    wr(4'd2, 32'h0);
    wr(4'd15, 32'h1); chk_eq("R8 accepted", got_ok, 1);
    wr(4'd2, 32'h10);
    wr(4'd8, 32'h1); chk_eq("R8 relocked reject", got_err, 1);
  endtask

  task automatic t_general;
    do_reset();
    wr(4'd0, KA); wr(4'd1, KB);
    wr(4'd3, 32'h5); chk_eq("R9 addr3 ok", got_ok, 1);
    wr(4'd7, 32'h5); chk_eq("R9 addr7 ok flag set", got_ok, 1);
    wr(4'd2, 32'h0);
    wr(4'd4, 32'h5); chk_eq("R9 addr4 ok flag clear", got_ok, 1);
  endtask

  task automatic t_back_to_back;
    do_reset();
    wr(4'd0, 32'h1234); chk_eq("R10 bad key accepted", got_ok, 1);
    wr(4'd0, KA); chk_eq("R10 key ok pulse", got_ok, 1);
    // back-to-back: completing key then protected write on consecutive cycles
    @(negedge clk); wr_valid = 1; wr_addr = 4'd1; wr_data = KB;
    @(negedge clk); wr_addr = 4'd5; wr_data = 32'h7;
    chk_eq("R10 key B ok", wr_ok, 1);
    @(negedge clk); wr_addr = 4'd1; wr_data = 32'h0;
    chk_eq("R10 next-cycle accept", wr_ok, 1);
    @(negedge clk); wr_addr = 4'd6;
    @(negedge clk); wr_valid = 0;
    chk_eq("R10 after bad key reject", wr_err, 1);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_unlock_orders(); t_partial(); t_wrong_key();
        t_read_keys(); t_locked_drop(); t_master_lock(); t_pll_gate();
        t_general(); t_back_to_back();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=%h expected=%h", 1, 0);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule